// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block models one programmable logic cell of the kind tiled across a reconfigurable fabric. It holds eight 4-input lookup tables and eight storage elements, split into two groups of four, plus a ninth flip-flop. Each group has its own user clock, clock enable, set/reset and clock polarity. Each storage element can be set up as an edge-triggered flip-flop or as a level-sensitive latch. A storage element takes its data from its LUT, from a direct cell input (which may be inverted), or from a constant 1 or constant 0.

Every truth table and mode bit lives in a 167-bit configuration vector, which is loaded serially. In arithmetic mode each LUT acts as the propagate term of a fast carry chain. The chain works either as two 4-bit adders or as one 8-bit adder. The ninth flip-flop can register the upper carry-out as a pipeline stage, or it can hold an independent data bit.

All logic runs on one system clock `clk`. The two user clocks `uclk` are treated as data and sampled on `clk`. A group's clock edges and active levels are found by comparing `uclk` with its value at the previous `clk` edge.

Top module: `lut_cell`

## Requirements
- R1: With arithmetic off, `f[i]` equals bit `A` of truth table `i`, where `A` is `lut_addr[4i+3:4i]`. Table `i` sits at configuration bits `[16i+15:16i]`.
- R2: While `cfg_en` is high, each `clk` edge shifts the configuration vector left by one and enters `cfg_din` at bit 0. After 167 shifts, the first bit sent sits at bit 166. The fields are laid out as follows:
  - element `i` uses bits `160..163` minus `32-4i`, that is, base `128+4i`: bits 1:0 hold the source, bit 2 the invert flag and bit 3 the latch flag;
  - group `g` uses bit `160+2g` for polarity and bit `161+2g` for the set/reset value;
  - bit 164 enables arithmetic, bit 165 selects 8-bit width and bit 166 sends the carry to the ninth flip-flop.
- R3: In flip-flop mode (latch flag 0), an element updates at the first `clk` edge that samples the active edge of its group's `uclk`. The active edge is rising when polarity is 0 and falling when polarity is 1. At any other edge the element holds its value.
- R4: In latch mode (latch flag 1), an element updates at every `clk` edge at which its group's `uclk` is at the active level. The active level is high for polarity 0 and low for polarity 1.
- R5: The source codes are 0 for the LUT result `f[i]`, 1 for `din[i]` XOR the invert flag, 2 for constant 1 and 3 for constant 0.
- R6: When an update occurs with the group's `ce` low and `lsr` low, the element keeps its value.
- R7: When an update occurs with the group's `lsr` high, the element takes the group's set/reset value, whatever `ce` is.
- R8: In arithmetic mode, bit `i` computes propagate `p` as the LUT value and generate as address bit 0. The sum is `f[i] = p ^ c`, and the next carry is `c` when `p` is 1, or the generate bit otherwise. With 8-bit width off, group `g` starts its chain from `cin[g]`, and `cout[g]` is that group's carry-out.
- R9: With 8-bit width on, group 1's carry-in is `cout[0]` and `cin[1]` has no effect.
- R10: The ninth flip-flop updates on group 0's active edge and uses group 0's `ce`, `lsr` and set/reset value. Its data is `cout[1]` when the carry bit is 1, and `d9` otherwise.
- R11: While `cfg_en` is high, no storage element and not the ninth flip-flop changes.
- R12: After reset, the configuration is all zeros and `q`, `q9` and `f` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift strobe |
| cfg_din | input | 1 | Serial configuration bit |
| lut_addr | input | 32 | Four address bits per LUT |
| din | input | 8 | Direct data input per element |
| cin | input | 2 | Carry-in per group |
| uclk | input | 2 | User clock per group |
| ce | input | 2 | Clock enable per group |
| lsr | input | 2 | Local set/reset per group |
| d9 | input | 1 | Independent data for the ninth flip-flop |
| f | output | 8 | Combinational LUT or sum results |
| q | output | 8 | Registered element outputs |
| cout | output | 2 | Carry-out per group |
| q9 | output | 1 | Ninth flip-flop output |

## Verification
`f` and `cout` are combinational, so they are due in the same cycle as the address and carry-in that drive them. The bench drives inputs just after a falling `clk` edge and checks these outputs 1 ns later. `q` and `q9` change at the first rising `clk` edge that samples the new `uclk` level, so exactly one `clk` edge separates a stimulus from its registered result. The bench works out the expected next state before that edge and compares at the following falling edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  localparam int DEF_K       = 4;
  localparam int DEF_N       = 4;
  localparam int ELEM_CFG_W  = 4;
  localparam int GRP_CFG_W   = 2;
  localparam int MODE_CFG_W  = 3;

  typedef enum logic [1:0] {
    SRC_LUT  = 2'd0,
    SRC_DIN  = 2'd1,
    SRC_ONE  = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  typedef struct packed {
    logic latch;
    logic inv;
    src_e src;
  } elem_cfg_t;

  typedef struct packed {
    logic srval;
    logic pol;
  } grp_cfg_t;

  // one carry-chain stage: returns {carry_next, sum}
  function automatic logic [1:0] carry_step(input logic p, input logic g, input logic c);
    return {(p ? c : g), (p ^ c)};
  endfunction

  function automatic int cfg_len(input int k, input int n);
    return 2 * n * ((1 << k) + ELEM_CFG_W) + 2 * GRP_CFG_W + MODE_CFG_W;
  endfunction

endpackage

// File: rtl/lut_cfg_shift.sv
module lut_cfg_shift #(
  parameter int W = 167
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_en) cfg <= {cfg[W-2:0], cfg_din};
  end

endmodule

// File: rtl/lut_store_elem.sv
module lut_store_elem (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic lsr,
  input  logic srval,
  input  logic ce,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (upd) begin
      if (lsr)     q <= srval;
      else if (ce) q <= d;
    end
  end

endmodule

// File: rtl/lut_group.sv
module lut_group
  import lut_cell_pkg::*;
#(
  parameter int K = DEF_K,
  parameter int N = DEF_N
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold,
  input  logic [N*(1<<K)-1:0]      tt,
  input  elem_cfg_t [N-1:0]        ecfg,
  input  grp_cfg_t                 gcfg,
  input  logic                     arith,
  input  logic [N*K-1:0]           addr,
  input  logic [N-1:0]             din,
  input  logic                     c_in,
  input  logic                     uclk,
  input  logic                     uclk_q,
  input  logic                     ce,
  input  logic                     lsr,
  output logic [N-1:0]             f,
  output logic [N-1:0]             q,
  output logic [N-1:0]             upd,
  output logic [N-1:0]             sr_hit,
  output logic                     c_out,
  output logic                     edge_ev
);

  localparam int TT = 1 << K;

  logic [N-1:0] prop;
  logic [N-1:0] sum;
  logic [N:0]   chain;
  logic         lvl;

  // active edge / active level of the sampled user clock
  assign edge_ev = ~hold & (gcfg.pol ? (uclk_q & ~uclk) : (~uclk_q & uclk));
  assign lvl     = ~hold & (uclk ^ gcfg.pol);

  always_comb begin
    chain[0] = c_in;
    for (int i = 0; i < N; i++) begin
      logic [TT-1:0] tbl;
      logic [K-1:0]  a;
      tbl     = tt[i*TT +: TT];
      a       = addr[i*K +: K];
      prop[i] = tbl[a];
      {chain[i+1], sum[i]} = carry_step(prop[i], a[0], chain[i]);
    end
  end

  assign c_out = chain[N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_elem
      logic d;
      assign f[i] = arith ? sum[i] : prop[i];

      always_comb begin
        case (ecfg[i].src)
          SRC_LUT: d = f[i];
          SRC_DIN: d = din[i] ^ ecfg[i].inv;
          SRC_ONE: d = 1'b1;
          default: d = 1'b0;
        endcase
      end

      assign upd[i]    = ecfg[i].latch ? lvl : edge_ev;
      assign sr_hit[i] = upd[i] & lsr;

      lut_store_elem u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd[i]),
        .lsr   (lsr),
        .srval (gcfg.srval),
        .ce    (ce),
        .d     (d),
        .q     (q[i])
      );
    end
  endgenerate

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int K = DEF_K,
  parameter int N = DEF_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [2*N*K-1:0] lut_addr,
  input  logic [2*N-1:0]   din,
  input  logic [1:0]       cin,
  input  logic [1:0]       uclk,
  input  logic [1:0]       ce,
  input  logic [1:0]       lsr,
  input  logic             d9,
  output logic [2*N-1:0]   f,
  output logic [2*N-1:0]   q,
  output logic [1:0]       cout,
  output logic             q9
);

  localparam int TT        = 1 << K;
  localparam int L         = 2 * N;
  localparam int ELEM_BASE = L * TT;
  localparam int GRP_BASE  = ELEM_BASE + L * ELEM_CFG_W;
  localparam int MODE_BASE = GRP_BASE + 2 * GRP_CFG_W;
  localparam int CFG_BITS  = cfg_len(K, N);

  logic [CFG_BITS-1:0] cfg;
  logic [1:0]          uclk_q;
  grp_cfg_t            gcfg0, gcfg1;
  logic                arith, wide8, nine_carry;
  logic                c_out0, c_out1, c_in1;
  logic                edge0, edge1;
  logic                nine_upd, nine_d;
  logic [L-1:0]        elem_upd, elem_sr_hit, elem_srv;

  lut_cfg_shift #(.W(CFG_BITS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .cfg     (cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uclk_q <= '0;
    else        uclk_q <= uclk;
  end

  assign gcfg0      = cfg[GRP_BASE +: GRP_CFG_W];
  assign gcfg1      = cfg[GRP_BASE + GRP_CFG_W +: GRP_CFG_W];
  assign arith      = cfg[MODE_BASE];
  assign wide8      = cfg[MODE_BASE + 1];
  assign nine_carry = cfg[MODE_BASE + 2];
  assign c_in1      = wide8 ? c_out0 : cin[1];

  lut_group #(.K(K), .N(N)) u_grp0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (cfg_en),
    .tt      (cfg[0 +: N*TT]),
    .ecfg    (cfg[ELEM_BASE +: N*ELEM_CFG_W]),
    .gcfg    (gcfg0),
    .arith   (arith),
    .addr    (lut_addr[0 +: N*K]),
    .din     (din[0 +: N]),
    .c_in    (cin[0]),
    .uclk    (uclk[0]),
    .uclk_q  (uclk_q[0]),
    .ce      (ce[0]),
    .lsr     (lsr[0]),
    .f       (f[0 +: N]),
    .q       (q[0 +: N]),
    .upd     (elem_upd[0 +: N]),
    .sr_hit  (elem_sr_hit[0 +: N]),
    .c_out   (c_out0),
    .edge_ev (edge0)
  );

  lut_group #(.K(K), .N(N)) u_grp1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (cfg_en),
    .tt      (cfg[N*TT +: N*TT]),
    .ecfg    (cfg[ELEM_BASE + N*ELEM_CFG_W +: N*ELEM_CFG_W]),
    .gcfg    (gcfg1),
    .arith   (arith),
    .addr    (lut_addr[N*K +: N*K]),
    .din     (din[N +: N]),
    .c_in    (c_in1),
    .uclk    (uclk[1]),
    .uclk_q  (uclk_q[1]),
    .ce      (ce[1]),
    .lsr     (lsr[1]),
    .f       (f[N +: N]),
    .q       (q[N +: N]),
    .upd     (elem_upd[N +: N]),
    .sr_hit  (elem_sr_hit[N +: N]),
    .c_out   (c_out1),
    .edge_ev (edge1)
  );

  assign cout     = {c_out1, c_out0};
  assign elem_srv = {{N{gcfg1.srval}}, {N{gcfg0.srval}}};

  // ninth flip-flop: pipeline stage for the upper carry or a free bit
  assign nine_upd = edge0;
  assign nine_d   = nine_carry ? c_out1 : d9;

  lut_store_elem u_nine (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (nine_upd),
    .lsr   (lsr[0]),
    .srval (gcfg0.srval),
    .ce    (ce[0]),
    .d     (nine_d),
    .q     (q9)
  );

  logic unused_edge1;
  assign unused_edge1 = edge1;

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
  parameter int L = 8,
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_en,
  input logic [L-1:0] q,
  input logic         q9,
  input logic [1:0]   ce,
  input logic [1:0]   lsr,
  input logic [1:0]   cout,
  input logic [L-1:0] upd,
  input logic [L-1:0] sr_hit,
  input logic [L-1:0] srv,
  input logic         nine_upd,
  input logic         nine_carry
);

  AST_HOLD_DURING_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> ($stable(q) && $stable(q9))); // R11

  AST_NINE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_upd && !lsr[0] && ce[0] && nine_carry) |=> (q9 == $past(cout[1]))); // R10

  generate
    for (genvar i = 0; i < L; i++) begin : g_chk
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd[i] |=> $stable(q[i])); // R3

      AST_SR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        sr_hit[i] |=> (q[i] == $past(srv[i]))); // R7

      AST_CE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd[i] && !sr_hit[i] && !ce[i/N]) |=> $stable(q[i])); // R6
    end
  endgenerate

endmodule

bind lut_cell lut_cell_chk #(.L(L), .N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .q          (q),
  .q9         (q9),
  .ce         (ce),
  .lsr        (lsr),
  .cout       (cout),
  .upd        (elem_upd),
  .sr_hit     (elem_sr_hit),
  .srv        (elem_srv),
  .nine_upd   (nine_upd),
  .nine_carry (nine_carry)
);

// File: tb/test_lut_cell.sv
`timescale 1ns/1ps
module test_lut_cell;

  localparam int CW = 167;
  localparam int EB = 128;
  localparam int GB = 160;
  localparam int MB = 164;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_din = 1'b0;
  logic [31:0] lut_addr = '0;
  logic [7:0]  din = '0;
  logic [1:0]  cin = '0, uclk = '0, ce = '0, lsr = '0;
  logic        d9 = 1'b0;
  logic [7:0]  f, q;
  logic [1:0]  cout;
  logic        q9;

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] cfgv = '0;
  logic [7:0]    exp_q = '0;
  logic          exp_q9 = 1'b0;
  logic [1:0]    prev_uclk = '0;
  string         tag_q [8];
  string         tag_9 = "R10";

  always #5 clk = ~clk;

  lut_cell i_lut_cell (
    .clk, .rst_n, .cfg_en, .cfg_din, .lut_addr, .din, .cin, .uclk,
    .ce, .lsr, .d9, .f, .q, .cout, .q9
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] comb_model(input logic [CW-1:0] c, input logic [31:0] a,
                                            input logic [1:0] ci);
    logic [7:0] fo;
    logic [1:0] co;
    logic       cy;
    cy = 1'b0;
    for (int g = 0; g < 2; g++) begin
      if (!(g == 1 && c[MB+1])) cy = ci[g];
      for (int i = 0; i < 4; i++) begin
        int k;
        logic [3:0] nib;
        logic p, s;
        k   = g * 4 + i;
        nib = a[k*4 +: 4];
        p   = c[k*16 + int'(nib)];
        s   = p ^ cy;
        if (!p) cy = nib[0];
        fo[k] = c[MB] ? s : p;
      end
      co[g] = cy;
    end
    return {co, fo};
  endfunction

  function automatic logic active_edge(input logic pl, input logic was, input logic now);
    if (pl) return was && !now;
    return !was && now;
  endfunction

  task automatic model_next();
    logic [9:0] cm;
    cm = comb_model(cfgv, lut_addr, cin);
    for (int i = 0; i < 8; i++) begin
      int g;
      logic pl, ev, dsel;
      logic [1:0] sc;
      g  = i / 4;
      pl = cfgv[GB + 2*g];
      sc = cfgv[EB + 4*i +: 2];
      ev = cfgv[EB + 4*i + 3] ? (uclk[g] ^ pl) : active_edge(pl, prev_uclk[g], uclk[g]);
      case (sc)
        2'd0: dsel = cm[i];
        2'd1: dsel = din[i] ^ cfgv[EB + 4*i + 2];
        2'd2: dsel = 1'b1;
        default: dsel = 1'b0;
      endcase
      if (cfg_en) begin
        tag_q[i] = "R11";
      end else if (ev && lsr[g]) begin
        tag_q[i] = "R7"; exp_q[i] = cfgv[GB + 2*g + 1];
      end else if (ev && !ce[g]) begin
        tag_q[i] = "R6";
      end else begin
        if (cfgv[EB + 4*i + 3]) tag_q[i] = "R4";
        else if (sc != 2'd0)    tag_q[i] = "R5";
        else                    tag_q[i] = "R3";
        if (ev) exp_q[i] = dsel;
      end
    end
    tag_9 = cfg_en ? "R11" : "R10";
    if (!cfg_en && active_edge(cfgv[GB], prev_uclk[0], uclk[0])) begin
      if (lsr[0])     exp_q9 = cfgv[GB + 1];
      else if (ce[0]) exp_q9 = cfgv[MB+2] ? cm[9] : d9;
    end
  endtask

  task automatic step();
    logic [9:0] cm;
    string tf;
    #1;
    if (!cfg_en) begin
      cm = comb_model(cfgv, lut_addr, cin);
      tf = cfgv[MB] ? (cfgv[MB+1] ? "R9" : "R8") : "R1";
      chk(tf, f, cm[7:0]);
      if (cfgv[MB]) chk(tf, cout, cm[9:8]);
    end
    model_next();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 8; i++) chk(tag_q[i], q[i], exp_q[i]);
    chk(tag_9, q9, exp_q9);
    prev_uclk = uclk;
  endtask

  task automatic load_cfg(input logic [CW-1:0] v);
    logic [7:0] q_before;
    logic       q9_before;
    q_before  = q;
    q9_before = q9;
    cfg_en = 1'b1;
    for (int k = CW - 1; k >= 0; k--) begin
      cfg_din = v[k];
      uclk = 2'($urandom);
      lsr  = 2'($urandom);
      ce   = 2'($urandom);
      step();
    end
    cfg_en = 1'b0;
    cfgv   = v;
    chk("R11", {q9, q}, {q9_before, q_before});
  endtask

  function automatic logic [31:0] ab_addr(input logic [7:0] a, input logic [7:0] b);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) r[i*4 +: 2] = {b[i], a[i]};
    return r;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CW-1:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R12", q, 8'h00);
    chk("R12", q9, 1'b0);
    chk("R12", f, 8'h00);
    @(negedge clk);

    // adder config: propagate table = a XOR b, 8-bit width, carry to ninth flop
    v = '0;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = 16'h6666;
    v[MB] = 1'b1; v[MB+1] = 1'b1; v[MB+2] = 1'b1;
    load_cfg(v);
    uclk = 2'b00; ce = 2'b11; lsr = 2'b00; cin = 2'b00;
    lut_addr = ab_addr(8'h8F, 8'h01);
    step();
    chk("R2", f, 8'h90);
    chk("R9", cout, 2'b01);
    cin = 2'b10;
    step();
    chk("R9", f, 8'h90);
    uclk = 2'b11;
    step();
    chk("R3", q, 8'h90);
    chk("R10", q9, 1'b0);
    lut_addr = ab_addr(8'hFF, 8'h01); cin = 2'b00; uclk = 2'b00;
    step();
    chk("R9", f, 8'h00);
    chk("R3", q, 8'h90);
    uclk = 2'b11;
    step();
    chk("R3", q, 8'h00);
    chk("R10", q9, 1'b1);

    v[MB+1] = 1'b0;
    load_cfg(v);
    uclk = 2'b11; lut_addr = ab_addr(8'h8F, 8'h01); cin = 2'b00;
    step();
    chk("R8", f, 8'h80);
    chk("R8", cout, 2'b01);
    cin = 2'b10;
    step();
    chk("R8", f, 8'h90);

    // source selection: LUT, direct, direct inverted, one, zero
    v = '0;
    v[EB + 4*1 +: 3] = 3'b001;
    v[EB + 4*2 +: 3] = 3'b101;
    v[EB + 4*3 +: 3] = 3'b010;
    v[EB + 4*4 +: 3] = 3'b011;
    v[EB + 4*5 +: 3] = 3'b001;
    v[EB + 4*6 +: 3] = 3'b010;
    v[EB + 4*7 +: 3] = 3'b011;
    v[GB + 1] = 1'b1;
    load_cfg(v);
    uclk = 2'b00; ce = 2'b11; lsr = 2'b00; din = 8'b0010_0010; lut_addr = '0;
    step();
    uclk = 2'b11;
    step();
    chk("R5", q, 8'h6E);
    uclk = 2'b00;
    step();
    uclk = 2'b11; lsr = 2'b11; ce = 2'b00;
    step();
    chk("R7", q, 8'h0F);
    uclk = 2'b00; lsr = 2'b00;
    step();
    uclk = 2'b11; din = 8'hFF;
    step();
    chk("R6", q, 8'h0F);

    // constrained random configurations and stimulus
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < CW; k++) v[k] = 1'($urandom);
      load_cfg(v);
      for (int c = 0; c < 400; c++) begin
        lut_addr = $urandom;
        din      = 8'($urandom);
        cin      = 2'($urandom);
        uclk     = uclk ^ 2'($urandom);
        ce       = {($urandom % 4) != 0, ($urandom % 4) != 0};
        lsr      = {($urandom % 8) == 0, ($urandom % 8) == 0};
        d9       = 1'($urandom);
        step();
      end
    end

    finish_run();
  end

endmodule